// File: doc/BRIEF.md
# Memory Fault Capture and Interrupt Unit

This unit sits beside a memory controller and records access faults reported by the detection logic. It tracks three fault classes: an address that decodes to no target, a translation lookup that lands on an invalid page, and an access that breaks a security rule. Each class has a sticky pending flag, a capture word that records who faulted and how, and a second word holding the faulting address. Only the first fault of a class is kept. Later faults of that class are dropped until software clears the pending flag.

Software reads and writes a small register space through a single-cycle port. Reads are combinational. Writes take effect on the next clock edge. A mask register picks which pending classes drive the single interrupt line. Pending flags are cleared by writing ones to them. Each class has its own capture layout, because downstream handlers decode those bit positions.

Top module: `mem_fault_capture`

## Requirements
- R1: A fault strobe of a class sets that class's pending flag on the next clock edge. The pending register sits at byte offset 0x00, with bit 0 for decode faults, bit 1 for invalid-page faults and bit 2 for security faults.
- R2: `irq` is high exactly when some pending flag is set whose bit is also set in the mask register. The mask register sits at offset 0x04, uses the same bit order as the pending register, and is read/write.
- R3: Writing the pending register clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: The decode capture word is at 0x10. It holds the client ID in bits 5:0 and has bit 31 set for a write. The faulting address is at 0x14.
- R5: The invalid-page capture word is at 0x18. Bit 0 is set for a write and the client ID is in bits 6:1. The faulting address is at 0x1C.
- R6: The security capture word is at 0x20. It holds the client ID in bits 5:0, the violation subtype in bit 30, and has bit 31 set for a write. The faulting address is at 0x24.
- R7: While a class's pending flag is set, further faults of that class leave its capture word and address unchanged.
- R8: If a fault arrives in the same cycle that software clears its class's flag, the flag stays set and the capture word and address take the new fault.
- R9: After reset, the pending flags, mask, capture words and addresses are all zero and `irq` is low.
- R10: A fault in one class leaves the capture words and addresses of the other classes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_vld | input | 1 | Decode fault strobe |
| dec_client | input | 6 | Client ID of the decode fault |
| dec_write | input | 1 | Decode fault was a write |
| dec_addr | input | 32 | Address of the decode fault |
| xlt_vld | input | 1 | Invalid-page fault strobe |
| xlt_client | input | 6 | Client ID of the invalid-page fault |
| xlt_write | input | 1 | Invalid-page fault was a write |
| xlt_addr | input | 32 | Address of the invalid-page fault |
| sec_vld | input | 1 | Security fault strobe |
| sec_client | input | 6 | Client ID of the security fault |
| sec_write | input | 1 | Security fault was a write |
| sec_kind | input | 1 | Security violation subtype |
| sec_addr | input | 32 | Address of the security fault |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Masked fault interrupt |

## Verification
Some properties are checked on every cycle:
- A strobe always sets its flag.
- A clear without a new fault always drops the flag.
- A set flag otherwise stays set.
- A capture pair never moves while its load is blocked.
- A loaded address always equals the strobed one.
- Every rise of `irq` traces back to a fault or a register write.

Other behaviour can only be shown by the directed scenarios:
- The exact bit layout of each capture word, including the shifted client field of the invalid-page class.
- The collision where a clear meets a new fault.
- Isolation between classes.
- The reset values as read through the register port.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

    // Fault classes; the value is the bit index in the pending and mask registers
    typedef enum logic [1:0] {
        CLS_DECODE = 2'd0,
        CLS_XLAT   = 2'd1,
        CLS_SECURE = 2'd2
    } fault_class_e;

    localparam int NUM_CLASSES  = 3;

    // Register byte offsets
    localparam int OFS_PENDING  = 'h00;
    localparam int OFS_MASK     = 'h04;
    localparam int OFS_CAP_BASE = 'h10;
    localparam int CAP_STRIDE   = 8;     // capture word followed by address word
    localparam int WORD_BYTES   = 4;

endpackage

// File: rtl/mfc_capture.sv
module mfc_capture
    import mfc_pkg::*;
#(
    parameter int CLASS_ID = 0,
    parameter int CLIENT_W = 6,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_vld,
    input  logic [CLIENT_W-1:0] evt_client,
    input  logic                evt_write,
    input  logic                evt_kind,
    input  logic [DATA_W-1:0]   evt_addr,
    input  logic                load_en,
    output logic [DATA_W-1:0]   info_q,
    output logic [DATA_W-1:0]   addr_q
);

    localparam int WRITE_POS = DATA_W - 1;
    localparam int KIND_POS  = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] info;
        logic [DATA_W-1:0] addr;
    } cap_state_t;

    cap_state_t        cur_q;
    cap_state_t        nxt_d;
    logic [DATA_W-1:0] packed_w;
    logic              kind_bit;

    // Only the security class records a subtype
    assign kind_bit = (CLASS_ID == int'(CLS_SECURE)) ? evt_kind : 1'b0;

    generate
        if (CLASS_ID == int'(CLS_XLAT)) begin : g_xlat_layout
            // Write flag at bit 0, client ID just above it
            always_comb begin
                packed_w                 = '0;
                packed_w[0]              = evt_write;
                packed_w[CLIENT_W:1]     = evt_client;
                packed_w[KIND_POS]       = kind_bit;
            end
        end else begin : g_std_layout
            // Client ID in low bits, write flag on top, subtype below it
            always_comb begin
                packed_w                 = '0;
                packed_w[CLIENT_W-1:0]   = evt_client;
                packed_w[KIND_POS]       = kind_bit;
                packed_w[WRITE_POS]      = evt_write;
            end
        end
    endgenerate

    always_comb begin
        nxt_d = cur_q;
        if (evt_vld && load_en) begin
            nxt_d.info = packed_w;
            nxt_d.addr = evt_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign info_q = cur_q.info;
    assign addr_q = cur_q.addr;

    // R7: a blocked load keeps the first fault's record
    a_r7_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(info_q) && $stable(addr_q)));

    // R4 R5 R6: a permitted load captures the strobed address
    a_r4_r5_r6_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && load_en) |=> (addr_q == $past(evt_addr)));

endmodule

// File: rtl/mfc_regs.sv
module mfc_regs
    import mfc_pkg::*;
#(
    parameter int NUM_CLS = 3,
    parameter int DATA_W  = 32,
    parameter int REG_AW  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr_en,
    input  logic [REG_AW-1:0]              reg_addr,
    input  logic [DATA_W-1:0]              reg_wdata,
    input  logic [NUM_CLS-1:0]             evt_vld,
    input  logic [NUM_CLS-1:0][DATA_W-1:0] cap_info,
    input  logic [NUM_CLS-1:0][DATA_W-1:0] cap_addr,
    output logic [NUM_CLS-1:0]             load_en,
    output logic [DATA_W-1:0]              reg_rdata,
    output logic                           irq
);

    typedef struct packed {
        logic [NUM_CLS-1:0] pending;
        logic [NUM_CLS-1:0] mask;
    } reg_state_t;

    reg_state_t         cur_q;
    reg_state_t         nxt_d;
    logic [NUM_CLS-1:0] clr;
    logic               hit_pending;
    logic               hit_mask;

    assign hit_pending = (reg_addr == REG_AW'(OFS_PENDING));
    assign hit_mask    = (reg_addr == REG_AW'(OFS_MASK));
    assign clr         = (reg_wr_en && hit_pending) ? reg_wdata[NUM_CLS-1:0] : '0;

    always_comb begin
        nxt_d         = cur_q;
        // A new fault wins over a clear in the same cycle
        nxt_d.pending = (cur_q.pending & ~clr) | evt_vld;
        if (reg_wr_en && hit_mask) begin
            nxt_d.mask = reg_wdata[NUM_CLS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // Capture is allowed when the flag is idle or being cleared right now
    assign load_en = ~cur_q.pending | clr;
    assign irq     = |(cur_q.pending & cur_q.mask);

    always_comb begin
        reg_rdata = '0;
        if (hit_pending) begin
            reg_rdata[NUM_CLS-1:0] = cur_q.pending;
        end
        if (hit_mask) begin
            reg_rdata[NUM_CLS-1:0] = cur_q.mask;
        end
        for (int i = 0; i < NUM_CLS; i++) begin
            if (reg_addr == REG_AW'(OFS_CAP_BASE + CAP_STRIDE * i)) begin
                reg_rdata = cap_info[i];
            end
            if (reg_addr == REG_AW'(OFS_CAP_BASE + CAP_STRIDE * i + WORD_BYTES)) begin
                reg_rdata = cap_addr[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_CLS; g++) begin : g_flag_chk
            // R1: a strobe always leaves its flag set
            a_r1_set_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
                evt_vld[g] |=> cur_q.pending[g]);
            // R3: a clear with no competing fault drops the flag
            a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[g] && !evt_vld[g]) |=> !cur_q.pending[g]);
            // R3: without a clear the flag is sticky
            a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_q.pending[g] && !clr[g]) |=> cur_q.pending[g]);
        end
    endgenerate

endmodule

// File: rtl/mem_fault_capture.sv
module mem_fault_capture
    import mfc_pkg::*;
#(
    parameter int CLIENT_W = 6,
    parameter int DATA_W   = 32,
    parameter int REG_AW   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_vld,
    input  logic [CLIENT_W-1:0] dec_client,
    input  logic                dec_write,
    input  logic [DATA_W-1:0]   dec_addr,
    input  logic                xlt_vld,
    input  logic [CLIENT_W-1:0] xlt_client,
    input  logic                xlt_write,
    input  logic [DATA_W-1:0]   xlt_addr,
    input  logic                sec_vld,
    input  logic [CLIENT_W-1:0] sec_client,
    input  logic                sec_write,
    input  logic                sec_kind,
    input  logic [DATA_W-1:0]   sec_addr,
    input  logic                reg_wr_en,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq
);

    localparam int NCLS = NUM_CLASSES;

    logic [NCLS-1:0]                vld_v;
    logic [NCLS-1:0][CLIENT_W-1:0]  client_v;
    logic [NCLS-1:0]                write_v;
    logic [NCLS-1:0]                kind_v;
    logic [NCLS-1:0][DATA_W-1:0]    addr_v;
    logic [NCLS-1:0]                load_en;
    logic [NCLS-1:0][DATA_W-1:0]    cap_info;
    logic [NCLS-1:0][DATA_W-1:0]    cap_addr;

    // Gather the per-class strobes into arrays indexed by class
    always_comb begin
        vld_v    = '0;
        client_v = '0;
        write_v  = '0;
        kind_v   = '0;
        addr_v   = '0;
        vld_v[CLS_DECODE]    = dec_vld;
        client_v[CLS_DECODE] = dec_client;
        write_v[CLS_DECODE]  = dec_write;
        addr_v[CLS_DECODE]   = dec_addr;
        vld_v[CLS_XLAT]      = xlt_vld;
        client_v[CLS_XLAT]   = xlt_client;
        write_v[CLS_XLAT]    = xlt_write;
        addr_v[CLS_XLAT]     = xlt_addr;
        vld_v[CLS_SECURE]    = sec_vld;
        client_v[CLS_SECURE] = sec_client;
        write_v[CLS_SECURE]  = sec_write;
        kind_v[CLS_SECURE]   = sec_kind;
        addr_v[CLS_SECURE]   = sec_addr;
    end

    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_cap
            mfc_capture #(
                .CLASS_ID (c),
                .CLIENT_W (CLIENT_W),
                .DATA_W   (DATA_W)
            ) i_capture (
                .clk        (clk),
                .rst_n      (rst_n),
                .evt_vld    (vld_v[c]),
                .evt_client (client_v[c]),
                .evt_write  (write_v[c]),
                .evt_kind   (kind_v[c]),
                .evt_addr   (addr_v[c]),
                .load_en    (load_en[c]),
                .info_q     (cap_info[c]),
                .addr_q     (cap_addr[c])
            );
        end
    endgenerate

    mfc_regs #(
        .NUM_CLS (NCLS),
        .DATA_W  (DATA_W),
        .REG_AW  (REG_AW)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .evt_vld   (vld_v),
        .cap_info  (cap_info),
        .cap_addr  (cap_addr),
        .load_en   (load_en),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // R2: the interrupt only rises after a fault or a register write
    a_r2_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dec_vld || xlt_vld || sec_vld || reg_wr_en));

endmodule

// File: tb/test_mem_fault_capture.sv
module test_mem_fault_capture;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_vld = 0, xlt_vld = 0, sec_vld = 0;
    logic [5:0]  dec_client = 0, xlt_client = 0, sec_client = 0;
    logic        dec_write = 0, xlt_write = 0, sec_write = 0, sec_kind = 0;
    logic [31:0] dec_addr = 0, xlt_addr = 0, sec_addr = 0;
    logic        reg_wr_en = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mem_fault_capture i_mem_fault_capture (
        .clk, .rst_n,
        .dec_vld, .dec_client, .dec_write, .dec_addr,
        .xlt_vld, .xlt_client, .xlt_write, .xlt_addr,
        .sec_vld, .sec_client, .sec_write, .sec_kind, .sec_addr,
        .reg_wr_en, .reg_addr, .reg_wdata, .reg_rdata, .irq
    );

    // Expected capture words, built from the layouts in the requirements
    function automatic logic [31:0] std_word(logic [5:0] cl, logic wr, logic kd);
        return {wr, kd, 24'd0, cl};
    endfunction
    function automatic logic [31:0] xlt_word(logic [5:0] cl, logic wr);
        return {25'd0, cl, wr};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic fire_dec(logic [5:0] cl, logic wr, logic [31:0] ad);
        @(negedge clk);
        dec_vld = 1; dec_client = cl; dec_write = wr; dec_addr = ad;
        @(negedge clk);
        dec_vld = 0;
    endtask

    task automatic fire_xlt(logic [5:0] cl, logic wr, logic [31:0] ad);
        @(negedge clk);
        xlt_vld = 1; xlt_client = cl; xlt_write = wr; xlt_addr = ad;
        @(negedge clk);
        xlt_vld = 0;
    endtask

    task automatic fire_sec(logic [5:0] cl, logic wr, logic kd, logic [31:0] ad);
        @(negedge clk);
        sec_vld = 1; sec_client = cl; sec_write = wr; sec_kind = kd; sec_addr = ad;
        @(negedge clk);
        sec_vld = 0;
    endtask

    task automatic t_reset;
        rd_check("R9 pending", 8'h00, 32'h0);
        rd_check("R9 mask", 8'h04, 32'h0);
        for (int i = 0; i < 6; i++) rd_check("R9 capture", 8'h10 + 8'(4 * i), 32'h0);
        check("R9 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_decode;
        fire_dec(6'h2A, 1'b1, 32'h8000_1234);
        rd_check("R1 decode flag", 8'h00, 32'h1);
        rd_check("R4 decode word", 8'h10, std_word(6'h2A, 1'b1, 1'b0));
        rd_check("R4 decode addr", 8'h14, 32'h8000_1234);
        check("R2 masked off", {31'd0, irq}, 32'h0);
        reg_write(8'h04, 32'h1);
        rd_check("R2 mask readback", 8'h04, 32'h1);
        check("R2 irq on", {31'd0, irq}, 32'h1);
    endtask

    task automatic t_hold;
        fire_dec(6'h05, 1'b0, 32'h0000_BEEF);
        rd_check("R7 word kept", 8'h10, std_word(6'h2A, 1'b1, 1'b0));
        rd_check("R7 addr kept", 8'h14, 32'h8000_1234);
    endtask

    task automatic t_w1c;
        reg_write(8'h00, 32'h6);
        rd_check("R3 zero bit ignored", 8'h00, 32'h1);
        check("R3 irq still", {31'd0, irq}, 32'h1);
        reg_write(8'h00, 32'h1);
        rd_check("R3 cleared", 8'h00, 32'h0);
        check("R3 irq low", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_xlat;
        fire_xlt(6'h3F, 1'b1, 32'h0000_1000);
        rd_check("R1 xlat flag", 8'h00, 32'h2);
        rd_check("R5 xlat word", 8'h18, xlt_word(6'h3F, 1'b1));
        rd_check("R5 xlat addr", 8'h1C, 32'h0000_1000);
        rd_check("R10 decode untouched", 8'h10, std_word(6'h2A, 1'b1, 1'b0));
        reg_write(8'h00, 32'h2);
        fire_xlt(6'h15, 1'b0, 32'hCAFE_0000);
        rd_check("R5 xlat read word", 8'h18, xlt_word(6'h15, 1'b0));
        check("R2 xlat unmasked", {31'd0, irq}, 32'h0);
        reg_write(8'h00, 32'h2);
    endtask

    task automatic t_sec;
        reg_write(8'h04, 32'h4);
        fire_sec(6'h11, 1'b0, 1'b1, 32'h4444_0000);
        rd_check("R6 sec word subtype", 8'h20, std_word(6'h11, 1'b0, 1'b1));
        rd_check("R6 sec addr", 8'h24, 32'h4444_0000);
        check("R2 sec irq", {31'd0, irq}, 32'h1);
        rd_check("R10 xlat untouched", 8'h18, xlt_word(6'h15, 1'b0));
        reg_write(8'h00, 32'h4);
        fire_sec(6'h01, 1'b1, 1'b0, 32'h0000_0040);
        rd_check("R6 sec word write", 8'h20, std_word(6'h01, 1'b1, 1'b0));
        reg_write(8'h00, 32'h4);
    endtask

    task automatic t_collide;
        fire_dec(6'h01, 1'b0, 32'h1111_1111);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = 8'h00; reg_wdata = 32'h1;
        dec_vld = 1; dec_client = 6'h02; dec_write = 1'b1; dec_addr = 32'h2222_2222;
        @(negedge clk);
        reg_wr_en = 0; dec_vld = 0;
        rd_check("R8 flag stays", 8'h00, 32'h1);
        rd_check("R8 word reload", 8'h10, std_word(6'h02, 1'b1, 1'b0));
        rd_check("R8 addr reload", 8'h14, 32'h2222_2222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_decode;
        t_hold;
        t_w1c;
        t_xlat;
        t_sec;
        t_collide;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule